// File: doc/BRIEF.md
# UART Channel FIFO Pair with Trigger and Timeout Interrupts

This block holds the data buffering for one serial channel. It has a transmit queue, which the host fills and the serial shifter drains, and a receive queue, which the shifter fills and the host drains. From the fill levels of the two queues it derives three interrupt lines: one for transmit space available, one for receive data available and one for a receive timeout. The timeout covers data that sits in the receive queue below the trigger level and would otherwise never raise an interrupt.

A control bit selects between queued operation at full depth and a legacy mode in which each direction holds a single byte. Each direction has its own trigger level, picked from four values by a 2-bit code. A transmit trigger that is written is only stored until a separate enhanced-mode bit is set. Until then the transmit side uses half the queue depth as its threshold. Register decoding and the serial shift logic sit outside this block.

Top module: `uart_fifo_irq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, both levels are 0, `tx_irq` is 1, and `rx_irq`, `rx_tmo_irq` and `rx_overrun` are 0.
- R2: With `fifo_en`=1 each queue holds DEPTH (32) bytes and returns them in the order written. A push while the queue is full is dropped. Levels update on the clock edge that samples the push or pop.
- R3: A receive push that is dropped because the queue is full sets `rx_overrun`. The flag stays set until a host receive pop, which clears it. If a drop and a pop occur in the same cycle, the set wins.
- R4: A pop from an empty queue leaves the read data and the level unchanged.
- R5: With `fifo_en`=0 each direction holds at most one byte. Any change of `fifo_en` empties both queues on the clock edge that sees the change.
- R6: `rx_irq` is 1 when the receive level is at or above the receive trigger. The trigger code is 0, 1, 2 or 3 and gives 8, 16, 24 or 28 bytes. With `fifo_en`=0 the threshold is 1 byte.
- R7: `tx_irq` is 1 when the free transmit space is at or above the effective transmit trigger. The trigger code uses the same encoding as R6. With `enh_en`=0 the effective trigger is 16. With `fifo_en`=0 the line is 1 only when the transmit byte is empty.
- R8: A `trig_wr` pulse stores both trigger codes. The receive code applies at once. The stored transmit code applies only while `enh_en`=1, which includes codes written while `enh_en` was 0. The stored transmit code is 1 after reset.
- R9: `rx_tmo_irq` asserts once the receive queue holds data below the receive trigger and 4 `char_tick` pulses have occurred since the last accepted receive push or pop. The line clears after such a push or pop, and when the queue is empty.
- R10: The interrupt outputs are registered. Each reflects the levels and settings one clock after those change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1: queued mode at full depth; 0: single-byte mode |
| enh_en | input | 1 | Enables the stored transmit trigger |
| trig_wr | input | 1 | Stores both trigger codes |
| rx_trig_sel | input | 2 | Receive trigger code |
| tx_trig_sel | input | 2 | Transmit trigger code |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte from host |
| tx_pop | input | 1 | Shifter takes a transmit byte |
| tx_rdata | output | 8 | Last transmit byte taken |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_wdata | input | 8 | Received byte from shifter |
| rx_pop | input | 1 | Host reads a received byte |
| rx_rdata | output | 8 | Last received byte read |
| char_tick | input | 1 | One pulse per character time |
| tx_level | output | 6 | Transmit fill level |
| rx_level | output | 6 | Receive fill level |
| tx_irq | output | 1 | Transmit space interrupt |
| rx_irq | output | 1 | Receive data interrupt |
| rx_tmo_irq | output | 1 | Receive timeout interrupt |
| rx_overrun | output | 1 | Receive overrun flag |

## Verification
A wrong pointer or level register shows on the level ports on the cycle after the faulty push or pop. It also shows as out-of-order read data at the latest when that entry is popped, which may be up to 32 operations later. A wrong stored trigger or timeout count shows only on the interrupt lines, one clock after the level or tick that should have changed them. For that reason the interrupts are compared against a level model after every operation, and the trigger and timeout boundaries are hit exactly.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // Trigger code to byte threshold: quarter, half, three quarters, depth less one eighth
  function automatic int trig_bytes(input logic [1:0] code, input int depth);
    case (code)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (depth * 3) / 4;
      default: return depth - depth / 8;
    endcase
  endfunction
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         single,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    cap;
  logic             full, push_ok, pop_ok;

  assign cap     = single ? LW'(1) : LW'(DEPTH);
  assign full    = (level >= cap);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & (level != '0) & ~flush;

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (pop_ok) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic empty,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(TICKS));

  always_ff @(posedge clk) begin
    if (rst || restart || empty) cnt <= '0;
    else if (tick && !expired)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int WIDTH     = 8,
  parameter int TMO_TICKS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fifo_en,
  input  logic                       enh_en,
  input  logic                       trig_wr,
  input  logic [1:0]                 rx_trig_sel,
  input  logic [1:0]                 tx_trig_sel,
  input  logic                       tx_push,
  input  logic [WIDTH-1:0]           tx_wdata,
  input  logic                       tx_pop,
  output logic [WIDTH-1:0]           tx_rdata,
  input  logic                       rx_push,
  input  logic [WIDTH-1:0]           rx_wdata,
  input  logic                       rx_pop,
  output logic [WIDTH-1:0]           rx_rdata,
  input  logic                       char_tick,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  output logic                       tx_irq,
  output logic                       rx_irq,
  output logic                       rx_tmo_irq,
  output logic                       rx_overrun
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          fifo_en_q, flush;
  logic [1:0]    rx_code_q, tx_code_q;
  logic [LW-1:0] cap, rx_thr, tx_thr, tx_free;
  logic          rx_full, rx_restart, tmo_expired;

  assign flush = fifo_en ^ fifo_en_q;
  assign cap   = fifo_en ? LW'(DEPTH) : LW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q <= 1'b0;
      rx_code_q <= 2'd0;
      tx_code_q <= 2'd1;
    end else begin
      fifo_en_q <= fifo_en;
      if (trig_wr) begin
        rx_code_q <= rx_trig_sel;
        tx_code_q <= tx_trig_sel;
      end
    end
  end

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk(clk), .rst(rst), .flush(flush), .single(~fifo_en),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
    .rdata(tx_rdata), .level(tx_level)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk(clk), .rst(rst), .flush(flush), .single(~fifo_en),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
    .rdata(rx_rdata), .level(rx_level)
  );

  assign rx_full    = (rx_level >= cap);
  assign rx_restart = (rx_push & ~rx_full) | (rx_pop & (rx_level != '0));

  uart_rx_timeout #(.TICKS(TMO_TICKS)) u_rx_tmo (
    .clk(clk), .rst(rst), .restart(rx_restart),
    .empty(rx_level == '0), .tick(char_tick), .expired(tmo_expired)
  );

  assign rx_thr  = fifo_en ? LW'(trig_bytes(rx_code_q, DEPTH)) : LW'(1);
  assign tx_thr  = !fifo_en ? LW'(1)
                 : (enh_en ? LW'(trig_bytes(tx_code_q, DEPTH)) : LW'(DEPTH / 2));
  assign tx_free = cap - tx_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq     <= 1'b1;
      rx_irq     <= 1'b0;
      rx_tmo_irq <= 1'b0;
    end else if (flush) begin
      tx_irq     <= 1'b1;
      rx_irq     <= 1'b0;
      rx_tmo_irq <= 1'b0;
    end else begin
      tx_irq     <= (tx_free >= tx_thr);
      rx_irq     <= (rx_level >= rx_thr);
      rx_tmo_irq <= tmo_expired && (rx_level != '0) && (rx_level < rx_thr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                             rx_overrun <= 1'b0;
    else if (rx_push && rx_full && !flush) rx_overrun <= 1'b1;
    else if (rx_pop)                     rx_overrun <= 1'b0;
  end
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       fifo_en,
  input logic                       rx_push,
  input logic                       rx_pop,
  input logic [WIDTH-1:0]           rx_rdata,
  input logic [$clog2(DEPTH+1)-1:0] tx_level,
  input logic [$clog2(DEPTH+1)-1:0] rx_level,
  input logic                       rx_irq,
  input logic                       rx_tmo_irq,
  input logic                       rx_overrun
);
  localparam int LW = $clog2(DEPTH + 1);

  AST_RX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_level <= LW'(DEPTH)); // R2
  AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    tx_level <= LW'(DEPTH)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && $past(fifo_en) && rx_level == LW'(DEPTH) && rx_push && !rx_pop)
    |=> (rx_overrun && rx_level == LW'(DEPTH))); // R3
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0 && rx_pop && !rx_push) |=> ($stable(rx_rdata) && rx_level == '0)); // R4
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !$past(fifo_en)) |-> (rx_level <= LW'(1) && tx_level <= LW'(1))); // R5
  AST_TMO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    rx_tmo_irq |-> !rx_irq); // R9
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_push(rx_push), .rx_pop(rx_pop),
  .rx_rdata(rx_rdata), .tx_level(tx_level), .rx_level(rx_level),
  .rx_irq(rx_irq), .rx_tmo_irq(rx_tmo_irq), .rx_overrun(rx_overrun)
);

// File: tb/uart_fifo_irq_tb.sv
module uart_fifo_irq_tb;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b1, enh_en = 1'b0, trig_wr = 1'b0;
  logic [1:0] rx_trig_sel = 2'd0, tx_trig_sel = 2'd1;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, char_tick = 1'b0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [5:0] tx_level, rx_level;
  logic tx_irq, rx_irq, rx_tmo_irq, rx_overrun;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] txq[$], rxq[$];
  logic [7:0] tx_last = '0, rx_last = '0;
  bit m_ovr = 1'b0, m_fen = 1'b1;
  int rxs = 0, txs = 1;

  always #5 clk = ~clk;

  uart_fifo_irq u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .enh_en(enh_en), .trig_wr(trig_wr),
    .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .char_tick(char_tick), .tx_level(tx_level), .rx_level(rx_level),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_tmo_irq(rx_tmo_irq), .rx_overrun(rx_overrun)
  );

  function automatic int trig(int code);
    case (code)
      0: return 8;
      1: return 16;
      2: return 24;
      default: return 28;
    endcase
  endfunction

  function automatic int cap();
    return m_fen ? DEPTH : 1;
  endfunction

  function automatic bit exp_rx_irq();
    return m_fen ? (rxq.size() >= trig(rxs)) : (rxq.size() >= 1);
  endfunction

  function automatic bit exp_tx_irq();
    int thr;
    thr = !m_fen ? 1 : (enh_en ? trig(txs) : 16);
    return (cap() - txq.size()) >= thr;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // one cycle of activity on the four queue ports, model updated alongside
  task automatic op(bit tp, bit tpo, bit rp, bit rpo, logic [7:0] d);
    bit full_before;
    tx_push = tp; tx_pop = tpo; rx_push = rp; rx_pop = rpo;
    tx_wdata = d; rx_wdata = ~d;
    step();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    full_before = (txq.size() >= cap());
    if (tpo && txq.size() > 0) tx_last = txq.pop_front();
    if (tp && !full_before) txq.push_back(d);
    full_before = (rxq.size() >= cap());
    if (rpo && rxq.size() > 0) rx_last = rxq.pop_front();
    if (rp && !full_before) rxq.push_back(~d);
    if (rp && full_before) m_ovr = 1;
    else if (rpo) m_ovr = 0;
  endtask

  task automatic check_data(string req);
    chk(req, tx_level, txq.size());
    chk(req, rx_level, rxq.size());
    chk(req, tx_rdata, tx_last);
    chk(req, rx_rdata, rx_last);
    chk(req, rx_overrun, m_ovr);
  endtask

  // interrupts are registered: one more clock before they reflect the levels (R10)
  task automatic check_irq(string req, bit exp_tmo);
    step();
    chk({req, " R10 rx_irq"}, rx_irq, exp_rx_irq());
    chk({req, " R10 tx_irq"}, tx_irq, exp_tx_irq());
    chk({req, " R9 tmo"}, rx_tmo_irq, exp_tmo);
  endtask

  task automatic set_trig(int r, int t);
    trig_wr = 1; rx_trig_sel = 2'(r); tx_trig_sel = 2'(t);
    step();
    trig_wr = 0; rxs = r; txs = t;
  endtask

  task automatic set_fen(bit v);
    fifo_en = v;
    step();
    if (v != m_fen) begin txq.delete(); rxq.delete(); end
    m_fen = v;
  endtask

  task automatic tick();
    char_tick = 1; step(); char_tick = 0; step();
  endtask

  task automatic drain();
    while (rxq.size() > 0) op(0, 0, 0, 1, 8'h00);
    while (txq.size() > 0) op(0, 1, 0, 0, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5A17);
    repeat (3) step();
    rst = 0;
    // R1: state right after reset
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_irq", tx_irq, 1);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 tmo", rx_tmo_irq, 0);
    chk("R1 ovr", rx_overrun, 0);
    step();

    // R7 / R8: stored transmit trigger inactive until enh_en
    set_trig(0, 3);
    for (int i = 0; i < 16; i++) op(1, 0, 0, 0, 8'(i + 8'h40));
    check_irq("R7 free16 default trig", 0);
    op(1, 0, 0, 0, 8'h50);
    check_irq("R7 free15 default trig", 0);
    enh_en = 1;
    check_irq("R8 stored 28 free15", 0);
    while (txq.size() > 5) op(0, 1, 0, 0, 8'h00);
    check_data("R2 tx order");
    check_irq("R8 free27", 0);
    op(0, 1, 0, 0, 8'h00);
    check_irq("R8 free28", 0);
    enh_en = 0;
    drain();

    // R2 / R3 / R4: fill receive queue, overflow, empty pop
    for (int i = 0; i < DEPTH; i++) op(0, 0, 1, 0, 8'(i * 7));
    check_data("R2 rx full");
    op(0, 0, 1, 0, 8'hEE);
    check_data("R3 overrun set");
    chk("R3 level stays 32", rx_level, 32);
    chk("R3 overrun flag", rx_overrun, 1);
    check_irq("R6 full", 0);
    op(0, 0, 1, 1, 8'hDD);
    check_data("R3 set wins over pop");
    op(0, 0, 0, 1, 8'h00);
    check_data("R3 cleared by pop");
    while (rxq.size() > 0) begin op(0, 0, 0, 1, 8'h00); check_data("R2 rx order"); end
    op(0, 0, 0, 1, 8'h00);
    check_data("R4 empty rx pop");
    op(0, 1, 0, 0, 8'h00);
    check_data("R4 empty tx pop");

    // R6: each receive trigger code at its boundary
    for (int s = 0; s < 4; s++) begin
      set_trig(s, 1);
      while (rxq.size() < trig(s) - 1) op(0, 0, 1, 0, 8'(s));
      check_irq("R6 below trig", 0);
      op(0, 0, 1, 0, 8'hA5);
      check_irq("R6 at trig", 0);
      drain();
    end

    // R9: timeout with trigger 8
    set_trig(0, 1);
    for (int i = 0; i < 3; i++) op(0, 0, 1, 0, 8'(i));
    for (int i = 0; i < 3; i++) tick();
    chk("R9 three ticks", rx_tmo_irq, 0);
    tick();
    chk("R9 four ticks", rx_tmo_irq, 1);
    op(0, 0, 0, 1, 8'h00);
    check_irq("R9 pop restarts", 0);
    for (int i = 0; i < 4; i++) tick();
    chk("R9 again after four", rx_tmo_irq, 1);
    op(0, 0, 1, 0, 8'h77);
    check_irq("R9 push restarts", 0);
    for (int i = 0; i < 4; i++) tick();
    drain();
    check_irq("R9 empty clears", 0);

    // R5: single-byte mode
    set_fen(0);
    check_data("R5 flush on disable");
    op(0, 0, 1, 0, 8'h11);
    op(0, 0, 1, 0, 8'h22);
    check_data("R5 rx one byte");
    check_irq("R5 byte mode irq", 0);
    op(1, 0, 0, 0, 8'h33);
    op(1, 0, 0, 0, 8'h34);
    check_data("R5 tx one byte");
    check_irq("R5 tx byte full", 0);
    op(0, 1, 0, 1, 8'h00);
    check_data("R5 byte pops");
    op(0, 0, 1, 0, 8'h44);
    op(1, 0, 0, 0, 8'h45);
    set_fen(1);
    check_data("R5 flush on enable");
    check_irq("R5 after flush", 0);

    // constrained random traffic in queued mode
    set_trig(1, 2);
    enh_en = 1;
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      op(r < 3, r >= 3 && r < 5, r >= 5 && r < 8, r >= 8, 8'($urandom));
      check_data("R2 random");
      if (n % 8 == 0) check_irq("R6 R7 random", 0);
    end

    done = 1;
    summary();
  end
endmodule